// File: doc/BRIEF.md
# Free-running match timer with watchdog reset

This block is the timekeeping unit for an operating system. It holds one up-counter that advances on each cycle where a tick-enable input is high, and several match registers. The count is compared against every match register each time the counter takes a new value. When a channel whose interrupt is enabled matches, it latches a status flag and holds its own interrupt line high until software clears the flag. Channel 3 can also issue a one-shot watchdog reset request.

Software reaches the block through a simple register port that has an address, write data, write strobe, read strobe and read data. Software can load the counter with any value, and counting continues upward from that value. Status flags are cleared by writing 1 to them. The watchdog has to be re-armed explicitly after every reset request it issues. Clock generation, bus bridging and the rest of the reset controller are outside this block.

Top module: `os_match_timer`

## Requirements
- R1: After reset the count, all match registers, the status, the interrupt-enable and the watchdog-arm registers read 0, and all `irq` lines and `wdt_rst` are low.
- R2: The register offsets are fixed. Match register N is at 4*N for N = 0..3. The count is at 0x10, the status at 0x14, the watchdog arm at 0x18 and the interrupt enable at 0x1C. A write to a match register is read back unchanged. `rdata` shows the addressed register from the clock edge at which `rd_en` is sampled high.
- R3: The interrupt-enable register keeps only bits 11:0, and bits 31:12 read as 0. Bit N enables channel N.
- R4: Any other offset reads as 0, and a write to it changes no register.
- R5: A write to the count loads the written value. Otherwise the count rises by exactly 1 on each clock edge where `tick_en` is high and holds when `tick_en` is low.
- R6: The count wraps from 0xFFFFFFFF to 0 on a tick.
- R7: A match occurs when the counter takes a new value, through a tick or a load, that equals match register N. If interrupt-enable bit N is 1, status bit N is set and `irq[N]` goes high on the next clock edge and stays high.
- R8: A match on a channel whose interrupt-enable bit is 0 sets neither its status bit nor its `irq` line.
- R9: A write to the status register clears exactly the bits written as 1, and the `irq` line of each cleared channel falls. Bits written as 0 are unaffected. A new match in the same cycle as a clear keeps the flag set.
- R10: If watchdog-arm bit 0 is 1 when channel 3 matches, `wdt_rst` is high for exactly one clock cycle and the arm register reads 0 afterwards. This happens whatever the value of interrupt-enable bit 3.
- R11: Once disarmed, further channel 3 matches produce no reset request until software writes 1 to the arm register. Only bit 0 of the arm register is stored.
- R12: A counter that stays at a matching value, or a match register rewritten to the current count, raises no new match. A cleared flag therefore stays clear while the counter is parked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Single-cycle count enable |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |
| irq | output | 4 | Per-channel interrupt lines, level until cleared |
| wdt_rst | output | 1 | One-cycle watchdog reset request |

## Verification
A wrong count shows at the ports in two places. It appears at the next read of offset 0x10. It also appears as an `irq` line that rises one cycle early, one cycle late or not at all after the expected tick. A stuck or mis-cleared status flag shows at once on its `irq` pin and at the next status read. A watchdog arm that fails to clear shows as a second `wdt_rst` pulse on the next channel 3 match. The bench therefore pairs every register read with pin checks taken a few cycles after each match or clear.

// File: rtl/ostmr_pkg.sv
package ostmr_pkg;
   // Byte offsets decoded by software; match channel N sits at MATCH_STRIDE*N.
   localparam int MATCH_STRIDE = 4;
   localparam int OFF_COUNT    = 'h10;
   localparam int OFF_STATUS   = 'h14;
   localparam int OFF_WDT_ARM  = 'h18;
   localparam int OFF_IRQ_EN   = 'h1C;
   localparam int MAX_CHANNELS = 4;
endpackage

// File: rtl/ostmr_counter.sv
module ostmr_counter #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              load_i,
   input  logic [DATA_W-1:0] load_val_i,
   output logic [DATA_W-1:0] cnt_o,
   output logic              moved_o
);
   logic [DATA_W-1:0] cnt_q;
   logic              moved_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         moved_q <= 1'b0;
      end else begin
         moved_q <= load_i | tick_i;
         if (load_i)
            cnt_q <= load_val_i;
         else if (tick_i)
            cnt_q <= cnt_q + DATA_W'(1);
      end
   end

   assign cnt_o   = cnt_q;
   assign moved_o = moved_q;

   // R5 R6
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && tick_i) |=> (cnt_q == $past(cnt_q) + DATA_W'(1)));
   // R5
   count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/ostmr_channel.sv
module ostmr_channel #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [DATA_W-1:0] cnt_i,
   input  logic              moved_i,
   input  logic              ien_i,
   input  logic              clr_i,
   output logic [DATA_W-1:0] match_o,
   output logic              hit_o,
   output logic              flag_o
);
   logic [DATA_W-1:0] match_q;
   logic              flag_q;

   // Only a freshly taken counter value can match.
   assign hit_o = moved_i && (cnt_i == match_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         match_q <= '0;
         flag_q  <= 1'b0;
      end else begin
         if (wr_i)
            match_q <= wdata_i;
         if (hit_o && ien_i)
            flag_q <= 1'b1;
         else if (clr_i)
            flag_q <= 1'b0;
      end
   end

   assign match_o = match_q;
   assign flag_o  = flag_q;

   // R9
   flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q) |-> $past(clr_i));
   // R7 R8
   flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(ien_i && hit_o));
endmodule

// File: rtl/ostmr_watchdog.sv
module ostmr_watchdog (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_i,
   input  logic wbit_i,
   input  logic hit_i,
   output logic arm_o,
   output logic rst_o
);
   logic arm_q;
   logic rst_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arm_q <= 1'b0;
         rst_q <= 1'b0;
      end else begin
         rst_q <= hit_i && arm_q;
         if (hit_i && arm_q)
            arm_q <= 1'b0;
         else if (wr_i)
            arm_q <= wbit_i;
      end
   end

   assign arm_o = arm_q;
   assign rst_o = rst_q;

   // R10
   rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_q |=> !rst_q);
   // R11
   rst_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_q |-> !arm_q);
   // R10
   rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_q) |-> $past(hit_i && arm_q));
endmodule

// File: rtl/os_match_timer.sv
module os_match_timer #(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 8,
   parameter int NUM_CH   = 4,
   parameter int IEN_W    = 12,
   parameter int WDT_CH   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wr_en,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rdata,
   output logic [NUM_CH-1:0] irq,
   output logic              wdt_rst
);
   import ostmr_pkg::*;

   localparam int STAT_PAD = DATA_W - NUM_CH;
   localparam int IEN_PAD  = DATA_W - IEN_W;

   generate
      if (NUM_CH < 1 || NUM_CH > MAX_CHANNELS) begin : g_bad_ch
         $error("NUM_CH must be 1..4");
      end
      if (WDT_CH >= NUM_CH) begin : g_bad_wdt
         $error("WDT_CH must name an existing channel");
      end
      if (IEN_W < NUM_CH || IEN_W >= DATA_W) begin : g_bad_ien
         $error("IEN_W must cover all channels and be narrower than DATA_W");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("ADDR_W too narrow for the register map");
      end
   endgenerate

   // ---------------- decode
   logic wr_count, wr_status, wr_arm, wr_ien;
   assign wr_count  = wr_en && (addr == ADDR_W'(OFF_COUNT));
   assign wr_status = wr_en && (addr == ADDR_W'(OFF_STATUS));
   assign wr_arm    = wr_en && (addr == ADDR_W'(OFF_WDT_ARM));
   assign wr_ien    = wr_en && (addr == ADDR_W'(OFF_IRQ_EN));

   // ---------------- counter
   logic [DATA_W-1:0] cnt;
   logic              moved;

   ostmr_counter #(.DATA_W(DATA_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_en), .load_i(wr_count),
      .load_val_i(wdata), .cnt_o(cnt), .moved_o(moved)
   );

   // ---------------- interrupt enable
   logic [IEN_W-1:0] ien_q;
   always_ff @(posedge clk) begin
      if (!rst_n)
         ien_q <= '0;
      else if (wr_ien)
         ien_q <= wdata[IEN_W-1:0];
   end

   // ---------------- match channels
   logic [DATA_W-1:0] match_val [NUM_CH];
   logic [NUM_CH-1:0] hit;
   logic [NUM_CH-1:0] flag;

   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      logic wr_match;
      assign wr_match = wr_en && (addr == ADDR_W'(MATCH_STRIDE * n));

      ostmr_channel #(.DATA_W(DATA_W)) u_ch (
         .clk(clk), .rst_n(rst_n), .wr_i(wr_match), .wdata_i(wdata),
         .cnt_i(cnt), .moved_i(moved), .ien_i(ien_q[n]),
         .clr_i(wr_status && wdata[n]),
         .match_o(match_val[n]), .hit_o(hit[n]), .flag_o(flag[n])
      );
   end

   assign irq = flag;

   // ---------------- watchdog
   logic arm;
   ostmr_watchdog u_wdt (
      .clk(clk), .rst_n(rst_n), .wr_i(wr_arm), .wbit_i(wdata[0]),
      .hit_i(hit[WDT_CH]), .arm_o(arm), .rst_o(wdt_rst)
   );

   // ---------------- readback
   logic [DATA_W-1:0] rd_mux;
   logic [DATA_W-1:0] rdata_q;

   always_comb begin
      rd_mux = '0;
      if (addr == ADDR_W'(OFF_COUNT))
         rd_mux = cnt;
      else if (addr == ADDR_W'(OFF_STATUS))
         rd_mux = {{STAT_PAD{1'b0}}, flag};
      else if (addr == ADDR_W'(OFF_WDT_ARM))
         rd_mux = {{(DATA_W-1){1'b0}}, arm};
      else if (addr == ADDR_W'(OFF_IRQ_EN))
         rd_mux = {{IEN_PAD{1'b0}}, ien_q};
      else begin
         for (int n = 0; n < NUM_CH; n++)
            if (addr == ADDR_W'(MATCH_STRIDE * n))
               rd_mux = match_val[n];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         rdata_q <= '0;
      else if (rd_en)
         rdata_q <= rd_mux;
   end

   assign rdata = rdata_q;

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (irq == '0 && !wdt_rst));
   // R3
   ien_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == ADDR_W'(OFF_IRQ_EN)) |=> (rdata[DATA_W-1:IEN_W] == '0));
endmodule

// File: tb/sim_os_match_timer.sv
module sim_os_match_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [31:0] rdata;
   logic [3:0]  irq;
   logic        wdt_rst;

   int checks = 0;
   int errors = 0;
   int rst_pulses = 0;
   logic [31:0] exp_q [$];
   string       tag_q [$];

   always #5 clk = ~clk;

   os_match_timer u0 (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .addr(addr),
      .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
      .irq(irq), .wdt_rst(wdt_rst)
   );

   always @(negedge clk) if (rst_n && wdt_rst) rst_pulses++;

   // Monitor: pop expected read data after the capturing edge.
   initial forever begin
      @(posedge clk);
      if (rd_en) begin
         #1;
         checks++;
         if (rdata !== exp_q[0]) begin
            errors++;
            $display("FAIL %s: rdata=%h expected %h", tag_q[0], rdata, exp_q[0]);
         end
         void'(exp_q.pop_front());
         void'(tag_q.pop_front());
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
      @(negedge clk); addr = a; rd_en = 1'b1;
      exp_q.push_back(e); tag_q.push_back(tag);
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick_en = 1'b1;
         @(negedge clk); tick_en = 1'b0;
      end
   endtask

   task automatic pin(input string tag, input logic [31:0] act, input logic [31:0] e);
      checks++;
      if (act !== e) begin
         errors++;
         $display("FAIL %s: actual=%h expected %h", tag, act, e);
      end
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   initial begin : watchdog_timer
      repeat (20000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: run hung");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      pin("R1 irq", {28'd0, irq}, 32'd0);
      pin("R1 wdt_rst", {31'd0, wdt_rst}, 32'd0);
      rd(8'h10, 32'd0, "R1 count");
      rd(8'h14, 32'd0, "R1 status");
      rd(8'h18, 32'd0, "R1 arm");
      rd(8'h1C, 32'd0, "R1 ien");
      rd(8'h04, 32'd0, "R1 match1");

      // R2 match registers
      wr(8'h00, 32'h1111_0000); wr(8'h04, 32'h2222_0001);
      wr(8'h08, 32'h3333_0002); wr(8'h0C, 32'h4444_0003);
      rd(8'h00, 32'h1111_0000, "R2 match0");
      rd(8'h04, 32'h2222_0001, "R2 match1");
      rd(8'h08, 32'h3333_0002, "R2 match2");
      rd(8'h0C, 32'h4444_0003, "R2 match3");

      // R3 interrupt enable width
      wr(8'h1C, 32'hFFFF_FFFF);
      rd(8'h1C, 32'h0000_0FFF, "R3 ien masked");
      wr(8'h1C, 32'h0);

      // R4 unmapped offsets
      wr(8'h24, 32'hDEAD_BEEF);
      wr(8'h02, 32'hDEAD_BEEF);
      rd(8'h24, 32'd0, "R4 unmapped read");
      rd(8'h00, 32'h1111_0000, "R4 match0 untouched");
      rd(8'h1C, 32'd0, "R4 ien untouched");

      // R5 load and count
      wr(8'h10, 32'd100);
      tick(5);
      rd(8'h10, 32'd105, "R5 count after 5 ticks");
      repeat (4) @(negedge clk);
      rd(8'h10, 32'd105, "R5 count holds");

      // R6 wrap
      wr(8'h10, 32'hFFFF_FFFF);
      tick(1);
      rd(8'h10, 32'd0, "R6 wrap");

      // R7 enabled match
      wr(8'h1C, 32'h1);
      wr(8'h00, 32'd200);
      wr(8'h10, 32'd199);
      settle();
      pin("R7 irq0 before match", {28'd0, irq}, 32'd0);
      tick(1);
      settle();
      pin("R7 irq0 after match", {28'd0, irq}, 32'h1);
      rd(8'h14, 32'h1, "R7 status");

      // R8 disabled channel
      wr(8'h04, 32'd300);
      wr(8'h10, 32'd299);
      tick(1);
      settle();
      pin("R8 irq1 stays low", {28'd0, irq}, 32'h1);
      rd(8'h14, 32'h1, "R8 status bit1 clear");

      // R9 write-one-to-clear
      wr(8'h14, 32'h0);
      settle();
      pin("R9 zero write keeps irq0", {28'd0, irq}, 32'h1);
      wr(8'h14, 32'h1);
      settle();
      pin("R9 irq0 dropped", {28'd0, irq}, 32'h0);
      rd(8'h14, 32'h0, "R9 status cleared");

      // R12 no re-match while parked
      wr(8'h10, 32'd200);
      settle();
      pin("R12 load onto match sets", {28'd0, irq}, 32'h1);
      wr(8'h14, 32'h1);
      repeat (6) @(negedge clk);
      pin("R12 parked counter no rematch", {28'd0, irq}, 32'h0);
      wr(8'h00, 32'd200);
      settle();
      pin("R12 match rewrite no rematch", {28'd0, irq}, 32'h0);

      // R10 watchdog fires once
      wr(8'h0C, 32'd500);
      wr(8'h18, 32'hFFFF_FFFF);
      rd(8'h18, 32'h1, "R11 arm keeps bit0 only");
      wr(8'h10, 32'd499);
      settle();
      pin("R10 no pulse before match", rst_pulses, 0);
      tick(1);
      settle();
      pin("R10 single pulse", rst_pulses, 1);
      rd(8'h18, 32'd0, "R10 arm cleared");
      rd(8'h14, 32'd0, "R10 status3 not set with ien3=0");

      // R11 disarmed stays quiet, re-arm works
      wr(8'h10, 32'd499);
      tick(1);
      settle();
      pin("R11 no pulse when disarmed", rst_pulses, 1);
      wr(8'h18, 32'h1);
      wr(8'h10, 32'd499);
      tick(1);
      settle();
      pin("R11 re-armed pulse", rst_pulses, 2);

      repeat (3) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule